// File: doc/BRIEF.md
# Tau Candidate Window Accumulator

This block builds one tau trigger object from a 7x7 neighbourhood of calorimeter tower energies centred on a candidate tower. An upstream scheduler opens a window with a start strobe. It then streams the 49 tower ET values one per cycle in row-major order, top-left first, and closes the window with an end strobe. With the end strobe it supplies a local-maximum verdict that was computed elsewhere.

Each tower is sorted by the integer part of its Euclidean distance from the centre. The 3x3 core feeds a cluster sum. The surrounding ring of 36 towers feeds an isolation sum. The four far corners feed neither sum. At the end of the window both sums are quantised to 200-unit steps and capped at 11 bits. They are then packed with the centre coordinates into a 32-bit object word. The word is released with a one-cycle valid pulse, but only when the window is complete, the centre is a local maximum and the quantised cluster ET meets a minimum threshold.

Top module: `tau_ring_builder`

## Requirements
- R1: For the tower at stream position p (0..48), let i = p/7-3 and j = p%7-3. The tower joins the cluster sum when i*i+j*j < 4, which gives the 9 core towers.
- R2: The tower joins the isolation sum when 4 <= i*i+j*j < 16, which gives 36 ring towers. The four corner towers (|i|=|j|=3) change neither sum.
- R3: The ET field is floor(cluster_sum/200), capped at 2047. The saturation bit (bit 0) is 1 exactly when this cap was applied.
- R4: The isolation field is floor(ring_sum/200), capped at 2047. Capping the isolation never sets the saturation bit.
- R5: The word layout is [31:27] = cand_eta-8 (5 bits), [26:23] = cand_phi-8 (4 bits), [22:12] = ET, [11:1] = isolation, [0] = saturation.
- R6: tob_valid pulses only for a window whose end strobe arrives with local_max=1. Without it, tob_valid stays 0.
- R7: When the ET field is below min_et, tob_valid stays 0. ET equal to min_et passes. Whenever tob_valid is 0, tob_word is 0.
- R8: win_start clears both sums and the tower count. A tower_valid in the same cycle as win_start is ignored.
- R9: If fewer than 49 towers were accepted when win_end arrives, win_err pulses and no object is emitted. Towers beyond the 49th in a window are ignored.
- R10: tob_valid, tob_word and win_err are registered. They appear in the cycle after the win_end edge and last one cycle. A tower_valid in the win_end cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_start | input | 1 | Opens a new window, clears the accumulators |
| tower_valid | input | 1 | A tower ET is present this cycle |
| tower_et | input | 16 | Tower ET, unsigned |
| win_end | input | 1 | Closes the window |
| local_max | input | 1 | Centre is a local maximum, sampled with win_end |
| cand_eta | input | 6 | Centre eta index |
| cand_phi | input | 5 | Centre phi index (8..23) |
| min_et | input | 11 | Minimum quantised ET for emission |
| tob_valid | output | 1 | Object word valid pulse |
| tob_word | output | 32 | Packed tau object |
| win_err | output | 1 | Window closed short of 49 towers |

## Verification
The bench places large energies on the four corner towers. A classifier that used the squared distance with an off-by-one bound would leak these into the isolation sum. It drives full-scale energy so that the cluster and isolation caps trip separately. A design that derived the saturation bit from the isolation cap, or from both caps, would flag the wrong word. It also sets the threshold exactly at the quantised ET, which a strict comparison would reject. Short windows, surplus towers and a restart in mid-window are each checked. These cases expose a design that emits from partial sums, accumulates past the 49th tower, or keeps the stale sums of an aborted window.

// File: rtl/tau_ring_pkg.sv
package tau_ring_pkg;

    typedef enum logic [1:0] {
        TC_NONE = 2'd0,
        TC_CORE = 2'd1,
        TC_HALO = 2'd2
    } tower_cls_e;

    localparam int ETA_FW = 5;
    localparam int PHI_FW = 4;
    localparam int Q_W    = 11;
    localparam int CORE_OFS = 8;

    typedef struct packed {
        logic [ETA_FW-1:0] eta;
        logic [PHI_FW-1:0] phi;
        logic [Q_W-1:0]    et;
        logic [Q_W-1:0]    iso;
        logic              sat;
    } tau_tob_t;

    // Class of a window position from its squared offset to the centre.
    function automatic tower_cls_e cls_of(input int idx, input int dim,
                                          input int core_r, input int halo_r);
        int half, di, dj, d2;
        half = dim / 2;
        di   = idx / dim - half;
        dj   = idx % dim - half;
        d2   = di * di + dj * dj;
        if (d2 < core_r * core_r)      return TC_CORE;
        else if (d2 < halo_r * halo_r) return TC_HALO;
        return TC_NONE;
    endfunction

endpackage

// File: rtl/tau_ring_classify.sv
module tau_ring_classify
    import tau_ring_pkg::*;
#(
    parameter int DIM    = 7,
    parameter int CORE_R = 2,
    parameter int HALO_R = 4,
    parameter int POS_W  = 6
) (
    input  logic [POS_W-1:0] pos,
    output tower_cls_e       cls
);
    localparam int N = DIM * DIM;

    tower_cls_e lut [N];

    for (genvar g = 0; g < N; g++) begin : g_lut
        assign lut[g] = cls_of(g, DIM, CORE_R, HALO_R);
    end

    always_comb begin
        cls = TC_NONE;
        for (int k = 0; k < N; k++) begin
            if (int'(pos) == k) cls = lut[k];
        end
    end
endmodule

// File: rtl/tau_ring_accum.sv
module tau_ring_accum
    import tau_ring_pkg::*;
#(
    parameter int ET_W  = 16,
    parameter int SUM_W = 22,
    parameter int N     = 49,
    parameter int POS_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             win_start,
    input  logic             win_end,
    input  logic             tower_valid,
    input  logic [ET_W-1:0]  tower_et,
    input  tower_cls_e       cls,
    output logic [POS_W-1:0] pos,
    output logic [SUM_W-1:0] core_sum,
    output logic [SUM_W-1:0] halo_sum
);
    logic accept;
    assign accept = tower_valid && !win_start && !win_end && (pos < POS_W'(N));

    always_ff @(posedge clk) begin
        if (rst || win_start) begin
            pos      <= '0;
            core_sum <= '0;
            halo_sum <= '0;
        end else if (accept) begin
            pos <= pos + 1'b1;
            if (cls == TC_CORE) core_sum <= core_sum + SUM_W'(tower_et);
            if (cls == TC_HALO) halo_sum <= halo_sum + SUM_W'(tower_et);
        end
    end

    assert_pos_bound_R9: assert property (@(posedge clk) disable iff (rst)
        pos <= POS_W'(N));

    assert_start_clears_R8: assert property (@(posedge clk) disable iff (rst)
        $past(win_start) |-> (pos == '0 && core_sum == '0 && halo_sum == '0));

    assert_full_holds_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(pos) == POS_W'(N) && !$past(win_start)) |-> $stable(halo_sum));
endmodule

// File: rtl/tau_ring_pack.sv
module tau_ring_pack
    import tau_ring_pkg::*;
#(
    parameter int SUM_W  = 22,
    parameter int ET_LSB = 200
) (
    input  logic [SUM_W-1:0] core_sum,
    input  logic [SUM_W-1:0] halo_sum,
    input  logic [5:0]       cand_eta,
    input  logic [4:0]       cand_phi,
    input  logic [Q_W-1:0]   min_et,
    output tau_tob_t         tob,
    output logic             pass
);
    localparam logic [SUM_W-1:0] QMAX = SUM_W'((1 << Q_W) - 1);
    localparam logic [SUM_W-1:0] DIV  = SUM_W'(ET_LSB);

    logic [SUM_W-1:0] core_q, halo_q;
    logic             core_cap, halo_cap;
    logic [5:0]       eta_rel;
    logic [4:0]       phi_rel;

    always_comb begin
        core_q   = core_sum / DIV;
        halo_q   = halo_sum / DIV;
        core_cap = core_q > QMAX;
        halo_cap = halo_q > QMAX;
        eta_rel  = cand_eta - 6'(CORE_OFS);
        phi_rel  = cand_phi - 5'(CORE_OFS);
        tob.eta  = eta_rel[ETA_FW-1:0];
        tob.phi  = phi_rel[PHI_FW-1:0];
        tob.et   = core_cap ? QMAX[Q_W-1:0] : core_q[Q_W-1:0];
        tob.iso  = halo_cap ? QMAX[Q_W-1:0] : halo_q[Q_W-1:0];
        tob.sat  = core_cap;
        pass     = tob.et >= min_et;
    end
endmodule

// File: rtl/tau_ring_builder.sv
module tau_ring_builder
    import tau_ring_pkg::*;
#(
    parameter int ET_W   = 16,
    parameter int DIM    = 7,
    parameter int CORE_R = 2,
    parameter int HALO_R = 4,
    parameter int ET_LSB = 200
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            win_start,
    input  logic            tower_valid,
    input  logic [ET_W-1:0] tower_et,
    input  logic            win_end,
    input  logic            local_max,
    input  logic [5:0]      cand_eta,
    input  logic [4:0]      cand_phi,
    input  logic [10:0]     min_et,
    output logic            tob_valid,
    output logic [31:0]     tob_word,
    output logic            win_err
);
    localparam int N     = DIM * DIM;
    localparam int POS_W = $clog2(N + 1);
    localparam int SUM_W = ET_W + $clog2(N);

    logic [POS_W-1:0] pos;
    logic [SUM_W-1:0] core_sum, halo_sum;
    tower_cls_e       cls;
    tau_tob_t         tob;
    logic             pass, short_win;

    tau_ring_classify #(.DIM(DIM), .CORE_R(CORE_R), .HALO_R(HALO_R), .POS_W(POS_W))
        u_cls (.pos(pos), .cls(cls));

    tau_ring_accum #(.ET_W(ET_W), .SUM_W(SUM_W), .N(N), .POS_W(POS_W))
        u_acc (.clk(clk), .rst(rst), .win_start(win_start), .win_end(win_end),
               .tower_valid(tower_valid), .tower_et(tower_et), .cls(cls),
               .pos(pos), .core_sum(core_sum), .halo_sum(halo_sum));

    tau_ring_pack #(.SUM_W(SUM_W), .ET_LSB(ET_LSB))
        u_pack (.core_sum(core_sum), .halo_sum(halo_sum), .cand_eta(cand_eta),
                .cand_phi(cand_phi), .min_et(min_et), .tob(tob), .pass(pass));

    assign short_win = pos < POS_W'(N);

    always_ff @(posedge clk) begin
        if (rst || win_start || !win_end) begin
            tob_valid <= 1'b0;
            tob_word  <= '0;
            win_err   <= 1'b0;
        end else begin
            win_err   <= short_win;
            tob_valid <= local_max && !short_win && pass;
            tob_word  <= (local_max && !short_win && pass) ? tob : '0;
        end
    end

    assert_valid_needs_lm_R6: assert property (@(posedge clk) disable iff (rst)
        tob_valid |-> $past(win_end && local_max));

    assert_err_blocks_word_R9: assert property (@(posedge clk) disable iff (rst)
        win_err |-> !tob_valid);

    assert_idle_word_zero_R7: assert property (@(posedge clk) disable iff (rst)
        !tob_valid |-> tob_word == '0);

    assert_sat_means_cap_R3: assert property (@(posedge clk) disable iff (rst)
        (tob_valid && tob_word[0]) |-> tob_word[22:12] == 11'h7FF);

    assert_threshold_met_R7: assert property (@(posedge clk) disable iff (rst)
        tob_valid |-> tob_word[22:12] >= $past(min_et));

    assert_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        $past(tob_valid) |-> !tob_valid || $past(win_end, 1));
endmodule

// File: tb/tb_tau_ring_builder.sv
`timescale 1ns/1ps
module tb_tau_ring_builder;
    logic        clk = 1'b0;
    logic        rst;
    logic        win_start, tower_valid, win_end, local_max;
    logic [15:0] tower_et;
    logic [5:0]  cand_eta;
    logic [4:0]  cand_phi;
    logic [10:0] min_et;
    logic        tob_valid, win_err;
    logic [31:0] tob_word;

    int checks = 0;
    int fails  = 0;
    int et_arr [0:63];

    always #2 clk = ~clk;

    tau_ring_builder dut (
        .clk(clk), .rst(rst), .win_start(win_start), .tower_valid(tower_valid),
        .tower_et(tower_et), .win_end(win_end), .local_max(local_max),
        .cand_eta(cand_eta), .cand_phi(cand_phi), .min_et(min_et),
        .tob_valid(tob_valid), .tob_word(tob_word), .win_err(win_err));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected word built from the requirements (R1..R5, R7).
    function automatic logic [31:0] exp_word(input int n, input int thr,
                                             input int ce, input int cp, output logic ok);
        int core, halo, q, iq, sat;
        int lim;
        core = 0; halo = 0;
        lim = (n > 49) ? 49 : n;
        for (int p = 0; p < lim; p++) begin
            int i, j, d2;
            i = p / 7 - 3; j = p % 7 - 3; d2 = i*i + j*j;
            if (d2 < 4) core += et_arr[p];
            else if (d2 < 16) halo += et_arr[p];
        end
        q = core / 200; sat = 0;
        if (q > 2047) begin q = 2047; sat = 1; end
        iq = halo / 200;
        if (iq > 2047) iq = 2047;
        ok = (q >= thr);
        return {5'((ce - 8) & 31), 4'((cp - 8) & 15), 11'(q), 11'(iq), 1'(sat)};
    endfunction

    task automatic open_win();
        @(negedge clk); win_start = 1'b1;
        @(negedge clk); win_start = 1'b0;
    endtask

    task automatic push(input int n);
        for (int p = 0; p < n; p++) begin
            tower_valid = 1'b1; tower_et = 16'(et_arr[p]);
            @(negedge clk);
        end
        tower_valid = 1'b0;
    endtask

    // Close, then sample outputs between the registering edge and the next.
    task automatic close_and_check(input string req, input int n, input logic lm,
                                   input int thr, input int ce, input int cp);
        logic ok;
        logic [31:0] w;
        w = exp_word(n, thr, ce, cp, ok);
        min_et = 11'(thr); cand_eta = 6'(ce); cand_phi = 5'(cp);
        local_max = lm; win_end = 1'b1;
        @(negedge clk);
        win_end = 1'b0; local_max = 1'b0;
        if (n < 49) begin
            chk({req, " err"},   {31'd0, win_err},   32'd1);
            chk({req, " valid"}, {31'd0, tob_valid}, 32'd0);
            chk({req, " word"},  tob_word,           32'd0);
        end else begin
            chk({req, " err"},   {31'd0, win_err},   32'd0);
            chk({req, " valid"}, {31'd0, tob_valid}, {31'd0, lm && ok});
            chk({req, " word"},  tob_word,           (lm && ok) ? w : 32'd0);
        end
        @(negedge clk);
        chk("R10 pulse ends", {30'd0, tob_valid, win_err}, 32'd0);
    endtask

    task automatic fill(input int core_v, input int halo_v, input int corner_v);
        for (int p = 0; p < 64; p++) begin
            int i, j, d2;
            i = p / 7 - 3; j = p % 7 - 3; d2 = i*i + j*j;
            if (p >= 49) et_arr[p] = 0;
            else if (d2 < 4) et_arr[p] = core_v;
            else if (d2 < 16) et_arr[p] = halo_v;
            else et_arr[p] = corner_v;
        end
    endtask

    task automatic t_uniform();   // R1 R2 R5: 45 / 180
        fill(1000, 1000, 1000); open_win(); push(49);
        close_and_check("R1 R2 R5 uniform", 49, 1'b1, 0, 12, 8);
    endtask

    task automatic t_corners();   // R2: corners excluded
        fill(0, 400, 60000); open_win(); push(49);
        close_and_check("R2 corners", 49, 1'b1, 0, 20, 23);
    endtask

    task automatic t_core_sat();  // R3
        fill(65535, 65535, 65535); open_win(); push(49);
        close_and_check("R3 cluster sat", 49, 1'b1, 0, 9, 15);
    endtask

    task automatic t_iso_sat();   // R4
        fill(2000, 20000, 0); open_win(); push(49);
        close_and_check("R4 iso sat no flag", 49, 1'b1, 0, 31, 17);
    endtask

    task automatic t_no_lm();     // R6
        fill(3000, 100, 0); open_win(); push(49);
        close_and_check("R6 no local max", 49, 1'b0, 0, 12, 12);
    endtask

    task automatic t_thresh();    // R7: et 45, min 46 blocks, 45 passes
        fill(1000, 500, 0); open_win(); push(49);
        close_and_check("R7 below thr", 49, 1'b1, 46, 14, 10);
        open_win(); push(49);
        close_and_check("R7 equal thr", 49, 1'b1, 45, 14, 10);
    endtask

    task automatic t_short();     // R9
        fill(1000, 1000, 0); open_win(); push(30);
        close_and_check("R9 short", 30, 1'b1, 0, 12, 8);
    endtask

    task automatic t_extra();     // R9: surplus towers ignored
        fill(1500, 700, 0);
        for (int p = 49; p < 55; p++) et_arr[p] = 65535;
        open_win(); push(55);
        close_and_check("R9 extra", 55, 1'b1, 0, 13, 11);
    endtask

    task automatic t_restart();   // R8
        fill(60000, 60000, 60000);
        open_win(); push(10);
        @(negedge clk);
        win_start = 1'b1; tower_valid = 1'b1; tower_et = 16'hFFFF;
        @(negedge clk);
        win_start = 1'b0; tower_valid = 1'b0;
        fill(800, 300, 0); push(49);
        close_and_check("R8 restart", 49, 1'b1, 0, 16, 16);
    endtask

    initial begin
        #(4ns * 200000);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; win_start = 0; tower_valid = 0; win_end = 0; local_max = 0;
        tower_et = '0; cand_eta = '0; cand_phi = '0; min_et = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 reset", {tob_word[30:0], tob_valid} | {31'd0, win_err}, 32'd0);
        t_uniform();
        t_corners();
        t_core_sat();
        t_iso_sat();
        t_no_lm();
        t_thresh();
        t_short();
        t_extra();
        t_restart();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule